// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a transmit command FIFO and a byte-level I2C bus engine. It reads 11-bit command words from the head of the FIFO. For each command it decides whether a START, a repeated START or a STOP condition is needed, and whether the byte is written or read. It passes each bus operation to the engine through a request/done handshake. When an operation completes, the engine returns the acknowledge result and, for reads, the received byte. Received bytes are passed on as a single-cycle valid pulse with data, which feeds a receive FIFO.

Every command word carries its own STOP-after and RESTART-before flags. When the transfer direction changes, a repeated START is inserted without being asked for. If the FIFO runs dry and the last byte did not request a STOP, the bus stays open and a hold flag is raised. Any failure, and any user abort, ends the transfer with a STOP. The remaining commands are then flushed and counted, and the abort cause is reported as a one-hot vector.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command word holds data in bits [7:0], read(1)/write(0) in bit 8, STOP-after in bit 9 and RESTART-before in bit 10. A transfer opens with a START, then a WRITE of the address byte {tar_addr, read bit}, then the data operation. Operation codes on req_op are 0 START, 1 RESTART, 2 STOP, 3 WRITE, 4 READ. req_op and req_byte stay stable while req_valid waits for eng_done.
- R2: A command with STOP-after set is followed by a STOP, after which the sequencer returns to idle. mst_active is 0 only while the sequencer is idle.
- R3: With restart_en high, a command whose direction differs from the previous data byte is preceded by a RESTART and a new address byte.
- R4: With restart_en high, a command with RESTART-before set is preceded by a RESTART and an address byte even without a direction change. With restart_en low, that flag has no effect.
- R5: With restart_en low, a direction change is carried out as a STOP followed by a fresh START and address byte.
- R6: When the FIFO is empty after a byte without STOP, the bus is held open. hold_empty reads 1, mst_active stays 1 and no request is made until a new command arrives.
- R7: No transfer starts while cmd_block is high or enable is low, even with commands queued. The commands stay in the FIFO. A transfer starts once both conditions clear.
- R8: A NACK to the address byte sets abort_src bit 0. A STOP is issued, every remaining command is popped, and flush_cnt reports how many were popped.
- R9: A NACK to a written data byte after an acknowledged address sets abort_src bit 1. The NACKed command is consumed, and the remaining commands are flushed and counted.
- R10: With gcall high the address byte is 0x00. A NACK to it sets abort_src bit 2. A read command following a general call sets abort_src bit 3, without reaching the bus.
- R11: While abort_req is high the sequencer sets abort_src bit 4. If the bus is open it issues a STOP, then it flushes the FIFO and pulses abort_done once before returning to idle.
- R12: Each completed READ produces one rx_valid pulse carrying the engine's byte. A READ whose command has STOP-after set is requested with req_last = 1, so the engine NACKs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new transfers to start |
| restart_en | input | 1 | Allows repeated START conditions |
| cmd_block | input | 1 | Holds off transfer start and continuation |
| abort_req | input | 1 | User abort request, held until abort_done |
| gcall | input | 1 | Address all slaves (general call) instead of tar_addr |
| tar_addr | input | 7 | Target slave address |
| cmd_valid | input | 1 | Command FIFO not empty |
| cmd_word | input | 11 | Command at FIFO head |
| cmd_pop | output | 1 | Remove the head command |
| req_valid | output | 1 | Bus operation requested |
| req_op | output | 3 | Operation code |
| req_byte | output | 8 | Byte to write |
| req_last | output | 1 | Read is the last one: NACK it |
| eng_done | input | 1 | Engine finished the operation (one cycle) |
| eng_ack | input | 1 | Slave acknowledged the written byte |
| eng_rdata | input | 8 | Byte read from the bus |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| mst_active | output | 1 | Sequencer not idle |
| hold_empty | output | 1 | Bus held open with an empty FIFO |
| abort_done | output | 1 | User abort completed (one cycle) |
| abort_src | output | 5 | One-hot cause of the last abort |
| flush_cnt | output | 8 | Commands flushed by the last abort |

## Verification
The bench records the exact sequence of bus operations and compares it with sequences built from the rules. This shows when a design adds a spurious RESTART for a same-direction byte, or drops a needed RESTART on a direction change. It also shows when a design honours the RESTART flag with repeated starts disabled, or emits a RESTART where a STOP and fresh START are required. Abort cases check the flush count, so an off-by-one that counts the NACKed byte, or leaves a stale command behind, is reported. The empty-FIFO hold is checked for an erroneous STOP or request. A general-call read must abort before touching the bus, and an abort request that is never acknowledged would hang the run.

// File: rtl/i2c_cmd_seq_pkg.sv
package i2c_cmd_seq_pkg;

  localparam int BYTE_W  = 8;
  localparam int ADDR7_W = 7;
  localparam int CMD_W   = BYTE_W + 3;
  localparam int BIT_RD   = BYTE_W;
  localparam int BIT_STOP = BYTE_W + 1;
  localparam int BIT_RS   = BYTE_W + 2;

  localparam int CAUSE_W = 5;
  localparam int IDX_W   = $clog2(CAUSE_W);
  localparam logic [IDX_W-1:0] C_ADDR_NACK = 0;
  localparam logic [IDX_W-1:0] C_DATA_NACK = 1;
  localparam logic [IDX_W-1:0] C_GC_NACK   = 2;
  localparam logic [IDX_W-1:0] C_GC_READ   = 3;
  localparam logic [IDX_W-1:0] C_USER      = 4;

  typedef enum logic [2:0] {
    OP_START = 3'd0, OP_RESTART = 3'd1, OP_STOP = 3'd2,
    OP_WRITE = 3'd3, OP_READ = 3'd4
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COND, ST_ADDR, ST_DATA, ST_STOP, ST_NEXT, ST_FLUSH
  } seq_st_e;

  typedef enum logic [1:0] { AFTER_IDLE, AFTER_START, AFTER_FLUSH } post_stop_e;

  // New address phase needed before the next byte?
  function automatic logic new_phase(input logic rs_flag, input logic new_rd,
                                     input logic prev_rd, input logic rs_en);
    return rs_en ? (rs_flag || (new_rd != prev_rd)) : (new_rd != prev_rd);
  endfunction

  function automatic logic [BYTE_W-1:0] addr_byte(input logic [ADDR7_W-1:0] tar,
                                                 input logic rd, input logic gc);
    return gc ? '0 : {tar, rd};
  endfunction

endpackage

// File: rtl/i2c_cmd_seq_decode.sv
module i2c_cmd_seq_decode
  import i2c_cmd_seq_pkg::*;
(
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic               prev_rd,
  input  logic               restart_en,
  input  logic               gcall,
  input  logic [ADDR7_W-1:0] tar_addr,
  output logic               cmd_rd,
  output logic               cmd_stop,
  output logic [BYTE_W-1:0]  cmd_byte,
  output logic [BYTE_W-1:0]  adr_byte,
  output logic               boundary,
  output logic               gc_read_bad
);
  assign cmd_rd      = cmd_word[BIT_RD];
  assign cmd_stop    = cmd_word[BIT_STOP];
  assign cmd_byte    = cmd_word[BYTE_W-1:0];
  assign adr_byte    = addr_byte(tar_addr, cmd_rd, gcall);
  assign boundary    = new_phase(cmd_word[BIT_RS], cmd_rd, prev_rd, restart_en);
  assign gc_read_bad = gcall && cmd_rd;
endmodule

// File: rtl/i2c_cmd_seq_abort.sv
module i2c_cmd_seq_abort
  import i2c_cmd_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             set_valid,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             flush_inc,
  output logic [CAUSE_W-1:0] cause,
  output logic [CNT_W-1:0]   flush_cnt
);
  for (genvar i = 0; i < CAUSE_W; i++) begin : g_cause
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cause[i] <= 1'b0;
      else if (set_valid) cause[i] <= (set_idx == IDX_W'(i));
      else if (clear)     cause[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       flush_cnt <= '0;
    else if (set_valid || clear)      flush_cnt <= '0;
    else if (flush_inc && flush_cnt != '1) flush_cnt <= flush_cnt + 1'b1;
  end

  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause)); // R8
  AST_FLUSH_ONLY_AFTER_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_inc && !set_valid && !clear) |=> (cause != '0)); // R8
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_cmd_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 restart_en,
  input  logic                 cmd_block,
  input  logic                 abort_req,
  input  logic                 gcall,
  input  logic [ADDR7_W-1:0]   tar_addr,
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_word,
  output logic                 cmd_pop,
  output logic                 req_valid,
  output logic [2:0]           req_op,
  output logic [BYTE_W-1:0]    req_byte,
  output logic                 req_last,
  input  logic                 eng_done,
  input  logic                 eng_ack,
  input  logic [BYTE_W-1:0]    eng_rdata,
  output logic                 rx_valid,
  output logic [BYTE_W-1:0]    rx_data,
  output logic                 mst_active,
  output logic                 hold_empty,
  output logic                 abort_done,
  output logic [CAUSE_W-1:0]   abort_src,
  output logic [CNT_W-1:0]     flush_cnt
);
  seq_st_e    st, st_d;
  post_stop_e post, post_d;
  logic       rs_sel, rs_d, prev_rd, prev_d;

  // named internal events
  logic             ev_begin, ev_abort, data_pop, flush_pop, rx_d;
  logic [IDX_W-1:0] ev_cause;

  logic              cmd_rd, cmd_stop, boundary, gc_read_bad;
  logic [BYTE_W-1:0] cmd_byte, adr_byte;

  i2c_cmd_seq_decode u_dec (
    .cmd_word, .prev_rd, .restart_en, .gcall, .tar_addr,
    .cmd_rd, .cmd_stop, .cmd_byte, .adr_byte, .boundary, .gc_read_bad
  );

  i2c_cmd_seq_abort #(.CNT_W(CNT_W)) u_abt (
    .clk, .rst_n, .clear(ev_begin), .set_valid(ev_abort), .set_idx(ev_cause),
    .flush_inc(flush_pop), .cause(abort_src), .flush_cnt
  );

  always_comb begin
    st_d = st; post_d = post; rs_d = rs_sel; prev_d = prev_rd;
    ev_begin = 1'b0; ev_abort = 1'b0; ev_cause = C_USER;
    data_pop = 1'b0; flush_pop = 1'b0; rx_d = 1'b0;
    case (st)
      ST_IDLE: begin
        if (abort_req) begin
          ev_abort = 1'b1; st_d = ST_FLUSH;
        end else if (enable && cmd_valid && !cmd_block) begin
          ev_begin = 1'b1;
          if (gc_read_bad) begin
            ev_abort = 1'b1; ev_cause = C_GC_READ; st_d = ST_FLUSH;
          end else begin
            rs_d = 1'b0; st_d = ST_COND;
          end
        end
      end
      ST_COND: if (eng_done) begin
        if (abort_req) begin
          ev_abort = 1'b1; post_d = AFTER_FLUSH; st_d = ST_STOP;
        end else st_d = ST_ADDR;
      end
      ST_ADDR: if (eng_done) begin
        if (!eng_ack) begin
          ev_abort = 1'b1; ev_cause = gcall ? C_GC_NACK : C_ADDR_NACK;
          post_d = AFTER_FLUSH; st_d = ST_STOP;
        end else if (abort_req) begin
          ev_abort = 1'b1; post_d = AFTER_FLUSH; st_d = ST_STOP;
        end else st_d = ST_DATA;
      end
      ST_DATA: if (eng_done) begin
        data_pop = 1'b1; prev_d = cmd_rd; rx_d = cmd_rd;
        if (!cmd_rd && !eng_ack) begin
          ev_abort = 1'b1; ev_cause = C_DATA_NACK;
          post_d = AFTER_FLUSH; st_d = ST_STOP;
        end else if (abort_req) begin
          ev_abort = 1'b1; post_d = AFTER_FLUSH; st_d = ST_STOP;
        end else if (cmd_stop) begin
          post_d = AFTER_IDLE; st_d = ST_STOP;
        end else st_d = ST_NEXT;
      end
      ST_NEXT: begin
        if (abort_req) begin
          ev_abort = 1'b1; post_d = AFTER_FLUSH; st_d = ST_STOP;
        end else if (cmd_valid && !cmd_block) begin
          if (gc_read_bad) begin
            ev_abort = 1'b1; ev_cause = C_GC_READ;
            post_d = AFTER_FLUSH; st_d = ST_STOP;
          end else if (!boundary) st_d = ST_DATA;
          else if (restart_en) begin
            rs_d = 1'b1; st_d = ST_COND;
          end else begin
            post_d = AFTER_START; st_d = ST_STOP;
          end
        end
      end
      ST_STOP: if (eng_done) begin
        case (post)
          AFTER_START: begin rs_d = 1'b0; st_d = ST_COND; end
          AFTER_FLUSH: st_d = ST_FLUSH;
          default:     st_d = ST_IDLE;
        endcase
      end
      ST_FLUSH: begin
        if (cmd_valid) flush_pop = 1'b1;
        else           st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; post <= AFTER_IDLE; rs_sel <= 1'b0; prev_rd <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0;
    end else begin
      st <= st_d; post <= post_d; rs_sel <= rs_d; prev_rd <= prev_d;
      rx_valid <= rx_d;
      if (rx_d) rx_data <= eng_rdata;
    end
  end

  always_comb begin
    req_op   = OP_STOP;
    req_byte = '0;
    case (st)
      ST_COND: req_op = rs_sel ? OP_RESTART : OP_START;
      ST_ADDR: begin req_op = OP_WRITE; req_byte = adr_byte; end
      ST_DATA: begin req_op = cmd_rd ? OP_READ : OP_WRITE; req_byte = cmd_byte; end
      default: req_op = OP_STOP;
    endcase
  end

  assign req_valid  = (st == ST_COND) || (st == ST_ADDR) || (st == ST_DATA) || (st == ST_STOP);
  assign req_last   = (st == ST_DATA) && cmd_stop;
  assign cmd_pop    = data_pop || flush_pop;
  assign mst_active = (st != ST_IDLE);
  assign hold_empty = (st == ST_NEXT) && !cmd_valid;
  assign abort_done = (st == ST_FLUSH) && !cmd_valid && abort_src[C_USER];

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !eng_done) |=> (req_valid && $stable(req_op) && $stable(req_byte))); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_active |-> (!req_valid && !cmd_pop)); // R2
  AST_HOLD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hold_empty |-> (!req_valid && mst_active && !cmd_pop)); // R6
  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_valid); // R8
  AST_ABORT_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> !mst_active); // R11
  AST_RX_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(req_op) == OP_READ && $past(eng_done))); // R12
endmodule

// File: tb/i2c_cmd_seq_bench.sv
module i2c_cmd_seq_bench;
  localparam int LAT = 3;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, restart_en = 1'b1, cmd_block = 1'b0, abort_req = 1'b0, gcall = 1'b0;
  logic [6:0] tar_addr = 7'h2A;
  logic cmd_valid = 1'b0;
  logic [10:0] cmd_word = '0;
  logic cmd_pop, req_valid, req_last, rx_valid, mst_active, hold_empty, abort_done;
  logic [2:0] req_op;
  logic [7:0] req_byte, rx_data, eng_rdata;
  logic eng_done, eng_ack;
  logic [4:0] abort_src;
  logic [7:0] flush_cnt;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [10:0] fifo[$];
  int act[$], exp_q[$];
  int rx_q[$];
  int nack_at = -1, wr_idx = 0, rd_idx = 0, wait_n = 0;
  bit last_read_flag = 0, saw_done = 0;

  i2c_cmd_seq u_i2c_cmd_seq (
    .clk, .rst_n, .enable, .restart_en, .cmd_block, .abort_req, .gcall, .tar_addr,
    .cmd_valid, .cmd_word, .cmd_pop, .req_valid, .req_op, .req_byte, .req_last,
    .eng_done, .eng_ack, .eng_rdata, .rx_valid, .rx_data, .mst_active,
    .hold_empty, .abort_done, .abort_src, .flush_cnt
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int a, input int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, a, e);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // command FIFO model: pops on the clock edge
  initial forever begin
    @(posedge clk);
    if (cmd_pop && fifo.size() > 0) void'(fifo.pop_front());
    cmd_valid <= (fifo.size() > 0);
    cmd_word  <= (fifo.size() > 0) ? fifo[0] : 11'd0;
  end

  task automatic push(input logic [10:0] w);
    fifo.push_back(w);
    cmd_valid = 1'b1;
    cmd_word  = fifo[0];
  endtask

  // byte engine model and per-clock invariants
  initial begin
    eng_done = 0; eng_ack = 0; eng_rdata = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_empty) chk(!req_valid && mst_active, "R6 hold quiet", req_valid, 0);
        if (!mst_active) chk(!req_valid, "R2 idle quiet", req_valid, 0);
        if (rx_valid) rx_q.push_back(int'(rx_data));
      end
      if (eng_done) begin
        eng_done = 0; wait_n = 0;
      end else if (req_valid) begin
        wait_n++;
        if (wait_n == LAT) begin
          act.push_back(int'(req_op) * 256 + int'(req_byte));
          eng_ack = 1'b1;
          if (req_op == 3'd3) begin eng_ack = (wr_idx != nack_at); wr_idx++; end
          if (req_op == 3'd4) begin
            eng_rdata = 8'hA0 + 8'(rd_idx); rd_idx++; last_read_flag = req_last;
          end
          eng_done = 1;
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finish_run();
  end

  task automatic scn(input int nk);
    act.delete(); exp_q.delete(); rx_q.delete();
    nack_at = nk; wr_idx = 0; rd_idx = 0; saw_done = 0;
  endtask

  task automatic e(input int op, input int b);
    exp_q.push_back(op * 256 + b);
  endtask

  task automatic run_idle();
    int n = 0;
    repeat (3) begin
      @(negedge clk);
      if (abort_done) begin abort_req = 0; saw_done = 1; end
    end
    while (mst_active && n < 3000) begin
      @(negedge clk); n++;
      if (abort_done) begin abort_req = 0; saw_done = 1; end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic cmp_ops(input string req);
    chk(act.size() == exp_q.size(), {req, " op count"}, act.size(), exp_q.size());
    foreach (exp_q[i])
      if (i < act.size()) chk(act[i] == exp_q[i], {req, " op"}, act[i], exp_q[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 R2 reset state
    chk(!mst_active && !req_valid && !cmd_pop, "R2 reset quiet", mst_active, 0);
    chk(abort_src == 0 && flush_cnt == 0, "R8 reset causes", abort_src, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R2: two writes, STOP on the second
    scn(-1);
    push(11'h011); push(11'h222);
    e(0,0); e(3,8'h54); e(3,8'h11); e(3,8'h22); e(2,0);
    run_idle(); cmp_ops("R1 write pair");
    chk(!mst_active, "R2 idle after stop", mst_active, 0);
    chk(abort_src == 0, "R2 no abort", abort_src, 0);

    // R3 R12: direction change with restart enabled, last read
    scn(-1);
    push(11'h033); push(11'h300);
    e(0,0); e(3,8'h54); e(3,8'h33); e(1,0); e(3,8'h55); e(4,0); e(2,0);
    run_idle(); cmp_ops("R3 dir change");
    chk(rx_q.size() == 1 && rx_q[0] == 8'hA0, "R12 rx byte", rx_q.size() ? rx_q[0] : -1, 8'hA0);
    chk(last_read_flag, "R12 last read nack", last_read_flag, 1);

    // R4: restart flag, same direction
    scn(-1);
    push(11'h044); push(11'h645);
    e(0,0); e(3,8'h54); e(3,8'h44); e(1,0); e(3,8'h54); e(3,8'h45); e(2,0);
    run_idle(); cmp_ops("R4 restart flag");

    // R5 R4: restart disabled, flag ignored, direction change -> STOP+START
    restart_en = 0;
    scn(-1);
    push(11'h001); push(11'h402); push(11'h300);
    e(0,0); e(3,8'h54); e(3,8'h01); e(3,8'h02); e(2,0); e(0,0); e(3,8'h55); e(4,0); e(2,0);
    run_idle(); cmp_ops("R5 stop start");
    restart_en = 1;

    // R6: hold with empty FIFO
    scn(-1);
    push(11'h077);
    repeat (40) @(negedge clk);
    chk(hold_empty && mst_active, "R6 hold flag", hold_empty, 1);
    chk(act.size() == 3, "R6 no stop while held", act.size(), 3);
    push(11'h278);
    e(0,0); e(3,8'h54); e(3,8'h77); e(3,8'h78); e(2,0);
    run_idle(); cmp_ops("R6 resume");
    chk(!hold_empty, "R6 hold cleared", hold_empty, 0);

    // R7: command block and enable
    scn(-1);
    cmd_block = 1; push(11'h221);
    repeat (20) @(negedge clk);
    chk(!mst_active && act.size() == 0 && fifo.size() == 1, "R7 blocked", act.size(), 0);
    cmd_block = 0;
    e(0,0); e(3,8'h54); e(3,8'h21); e(2,0);
    run_idle(); cmp_ops("R7 unblocked");
    scn(-1);
    enable = 0; push(11'h223);
    repeat (20) @(negedge clk);
    chk(!mst_active && fifo.size() == 1, "R7 disabled", fifo.size(), 1);
    enable = 1;
    e(0,0); e(3,8'h54); e(3,8'h23); e(2,0);
    run_idle(); cmp_ops("R7 enabled");

    // R8: address NACK
    scn(0);
    push(11'h010); push(11'h211);
    e(0,0); e(3,8'h54); e(2,0);
    run_idle(); cmp_ops("R8 addr nack");
    chk(abort_src == 5'b00001, "R8 cause", abort_src, 1);
    chk(flush_cnt == 2 && fifo.size() == 0, "R8 flush count", flush_cnt, 2);

    // R9: data NACK
    scn(1);
    push(11'h020); push(11'h021); push(11'h222);
    e(0,0); e(3,8'h54); e(3,8'h20); e(2,0);
    run_idle(); cmp_ops("R9 data nack");
    chk(abort_src == 5'b00010, "R9 cause", abort_src, 2);
    chk(flush_cnt == 2 && fifo.size() == 0, "R9 flush count", flush_cnt, 2);

    // R10: general call NACK and read after general call
    gcall = 1;
    scn(0);
    push(11'h205);
    e(0,0); e(3,0); e(2,0);
    run_idle(); cmp_ops("R10 gcall nack");
    chk(abort_src == 5'b00100 && flush_cnt == 1, "R10 gcall nack cause", abort_src, 4);
    scn(-1);
    push(11'h005); push(11'h300);
    e(0,0); e(3,0); e(3,8'h05); e(2,0);
    run_idle(); cmp_ops("R10 gcall read");
    chk(abort_src == 5'b01000 && flush_cnt == 1, "R10 gcall read cause", abort_src, 8);
    gcall = 0;

    // R11: user abort while holding, then while idle and blocked
    scn(-1);
    push(11'h090);
    repeat (30) @(negedge clk);
    abort_req = 1;
    e(0,0); e(3,8'h54); e(3,8'h90); e(2,0);
    run_idle(); cmp_ops("R11 abort open bus");
    chk(saw_done && !abort_req, "R11 abort done", saw_done, 1);
    chk(abort_src == 5'b10000 && flush_cnt == 0, "R11 cause", abort_src, 16);
    scn(-1);
    cmd_block = 1; push(11'h001); push(11'h002); push(11'h203);
    @(negedge clk);
    abort_req = 1;
    run_idle(); cmp_ops("R11 abort idle");
    chk(saw_done && flush_cnt == 3 && fifo.size() == 0, "R11 idle flush", flush_cnt, 3);
    cmd_block = 0;

    finish_run();
  end
endmodule